// File: doc/BRIEF.md
# ADC Sequencer Register Interface

This block is the register front end of a multi-channel successive-approximation converter. A processor reaches it over a simple 32-bit register bus that carries byte, halfword and word accesses. Through that bus software sets up the input multiplexing and the reference mode, starts conversions, polls for them to finish and reads the 12-bit results.

Two conversion engines share one converter. The sample engine digitises one of two auxiliary inputs, chosen by a field in the configuration register. The battery engine digitises the battery input and can use a low reference. A start bit in the enable register launches one conversion. The bit stays set while the conversion runs, and the block clears it when the converter reports done. The result is then held in that engine's own data register, and a sticky completion flag is raised. Software can abort a running conversion by clearing its start bit. A power-down bit blocks all starts.

Top module: `adcseq_regs`

## Requirements
- R1: After reset the enable, configuration, control, status, both result and divider registers read 0, and conv_start and conv_pd are low.
- R2: A write changes only its byte lanes. Size 0 is a byte at lane addr[1:0], size 1 is a halfword at lanes {addr[1],0} and {addr[1],1}, and size 2 is all four lanes. Write data sits in its lanes. A read returns the whole 32-bit register on rd_data one clock after the request.
- R3: Setting bit 0 of the enable register (offset 0x00) gives a one-cycle conv_start pulse. conv_chan is 1 when configuration bits [1:0] (offset 0x04) equal 1, and 0 for any other value.
- R4: Setting bit 1 of the enable register starts the battery engine with conv_chan = 2. At that start, conv_lowref equals configuration bit 4.
- R5: An engine's enable bit reads 1 while its conversion runs and 0 once conv_done has arrived. The result is then held in bits [11:0] of offset 0x20 (sample engine) or 0x1C (battery engine), with the upper bits reading 0.
- R6: Status register (0x0C) bit 0 or bit 1 is set when the sample or battery engine completes. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: Clearing a running engine's enable bit aborts its conversion. A later conv_done then leaves that engine's result and status bit unchanged.
- R8: While enable bit 7 (power-down) is set, conv_pd is high, start bits are not accepted and read as 0, and conv_start stays low.
- R9: Only one conversion is in flight at a time. When both start bits are set, the sample engine is converted first and the battery engine second.
- R10: The control register (0x08, 8 bits) and the divider register (0x28, 32 bits) read back what was written. Writes to the result registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, lane aligned |
| rd_data | output | 32 | Read data, valid one cycle after a read |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 2 | 0 first aux, 1 second aux, 2 battery |
| conv_lowref | output | 1 | Low reference for this conversion |
| conv_pd | output | 1 | Converter power-down |
| conv_done | input | 1 | Conversion finished, result valid |
| conv_result | input | 12 | Converted value |

## Verification
Random rounds vary the multiplexer field over all four codes, the reference bit, the engine mask (sample, battery or both) and the converter value. This separates the two auxiliary inputs from each other and from the battery path, and shows that each result lands in its own register. Mask value 3 exposes the service order. Directed cases cover the rest: an abort between start and done, starts made while powered down, status bits cleared one at a time, and lane-limited writes to the divider, each showing a state that a wrong design would corrupt.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int RES_W  = 12;
    localparam int N_ENG  = 2;
    localparam int LANES  = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFF_EN   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_BAT  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_SMP  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_DIV  = 8'h28;

    localparam int PD_BIT = 7;

    typedef enum logic [1:0] {
        CH_AUX0 = 2'd0,
        CH_AUX1 = 2'd1,
        CH_BATT = 2'd2
    } chan_e;

    typedef struct packed {
        logic [7:0]        en;
        logic [1:0]        mux;
        logic              lowref;
        logic [7:0]        ctrl;
        logic [N_ENG-1:0]  stat;
        logic [RES_W-1:0]  smp;
        logic [RES_W-1:0]  bat;
        logic [DATA_W-1:0] div;
        logic              busy;
        logic              eng;
        logic              start;
        chan_e             chan;
        logic              lref_o;
        logic [DATA_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/adcseq_lane_merge.sv
module adcseq_lane_merge #(
    parameter int W = 32
) (
    input  logic [1:0]     offs,
    input  logic [1:0]     size,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   merged,
    output logic [W/8-1:0] lanes
);
    localparam int NL = W / 8;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam logic [1:0] LI = 2'(i);
        assign lanes[i] = (size >= 2'd2)
                       || (size == 2'd1 && LI[1] == offs[1])
                       || (size == 2'd0 && LI == offs);
        assign merged[i*8 +: 8] = lanes[i] ? wdata[i*8 +: 8] : cur[i*8 +: 8];
    end
endmodule

// File: rtl/adcseq_pick.sv
module adcseq_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_pri
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
    assign any = seen[N];
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
    import adcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              conv_start,
    output logic [1:0]        conv_chan,
    output logic              conv_lowref,
    output logic              conv_pd,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result
);
    regs_t q, d;

    logic [DATA_W-1:0] cur_word, merged;
    logic [LANES-1:0]  lanes;
    logic [N_ENG-1:0]  grant;
    logic [N_ENG-1:0]  pick_req;
    logic              grant_any;

    // read mux, also the old value for partial writes
    always_comb begin
        cur_word = '0;
        case (req_addr[ADDR_W-1:2])
            OFF_EN[ADDR_W-1:2]:   cur_word[7:0] = q.en;
            OFF_CFG[ADDR_W-1:2]:  begin
                cur_word[1:0] = q.mux;
                cur_word[4]   = q.lowref;
            end
            OFF_CTRL[ADDR_W-1:2]: cur_word[7:0] = q.ctrl;
            OFF_STAT[ADDR_W-1:2]: cur_word[N_ENG-1:0] = q.stat;
            OFF_BAT[ADDR_W-1:2]:  cur_word[RES_W-1:0] = q.bat;
            OFF_SMP[ADDR_W-1:2]:  cur_word[RES_W-1:0] = q.smp;
            OFF_DIV[ADDR_W-1:2]:  cur_word = q.div;
            default:              cur_word = '0;
        endcase
    end

    adcseq_lane_merge #(.W(DATA_W)) u_merge (
        .offs   (req_addr[1:0]),
        .size   (req_size),
        .cur    (cur_word),
        .wdata  (req_wdata),
        .merged (merged),
        .lanes  (lanes)
    );

    adcseq_pick #(.N(N_ENG)) u_pick (
        .req   (pick_req),
        .grant (grant),
        .any   (grant_any)
    );

    logic wr, rd;
    assign wr = req_valid & req_write;
    assign rd = req_valid & ~req_write;

    logic [7:0] en_w;
    always_comb begin
        en_w = q.en;
        if (wr && req_addr[ADDR_W-1:2] == OFF_EN[ADDR_W-1:2]) begin
            en_w = 8'h00;
            en_w[N_ENG-1:0] = merged[N_ENG-1:0];
            en_w[PD_BIT]    = merged[PD_BIT];
            if (merged[PD_BIT]) en_w[N_ENG-1:0] = '0;
        end
    end

    assign pick_req = q.en[N_ENG-1:0] & en_w[N_ENG-1:0];

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.en    = en_w;

        if (wr) begin
            case (req_addr[ADDR_W-1:2])
                OFF_CFG[ADDR_W-1:2]: begin
                    d.mux    = merged[1:0];
                    d.lowref = merged[4];
                end
                OFF_CTRL[ADDR_W-1:2]: d.ctrl = merged[7:0];
                OFF_STAT[ADDR_W-1:2]: if (lanes[0])
                    d.stat = q.stat & ~req_wdata[N_ENG-1:0];
                OFF_DIV[ADDR_W-1:2]:  d.div = merged;
                default: ;
            endcase
        end

        if (q.busy) begin
            if (!en_w[q.eng]) begin
                d.busy = 1'b0;              // aborted by software
            end else if (conv_done) begin
                if (q.eng) d.bat = conv_result;
                else       d.smp = conv_result;
                d.en[q.eng]   = 1'b0;
                d.stat[q.eng] = 1'b1;
                d.busy        = 1'b0;
            end
        end else if (grant_any) begin
            d.busy   = 1'b1;
            d.eng    = grant[1];
            d.start  = 1'b1;
            d.lref_o = q.lowref;
            if (grant[1])          d.chan = CH_BATT;
            else if (q.mux == 2'd1) d.chan = CH_AUX1;
            else                   d.chan = CH_AUX0;
        end

        if (rd) d.rdata = cur_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data     = q.rdata;
    assign conv_start  = q.start;
    assign conv_chan   = q.chan;
    assign conv_lowref = q.lref_o;
    assign conv_pd     = q.en[PD_BIT];
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_start,
    input logic [1:0] conv_chan,
    input logic       conv_done,
    input logic       busy,
    input logic [7:0] en_bits,
    input logic [1:0] stat_bits
);
    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R9
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> !conv_start);

    // R8
    pd_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_bits[7] |-> (en_bits[1:0] == 2'b00));

    // R6
    stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat_bits[0]) || $rose(stat_bits[1])) |-> $past(conv_done));

    // R4
    chan_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != 2'd3));
endmodule

bind adcseq_regs adcseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .busy       (q.busy),
    .en_bits    (q.en),
    .stat_bits  (q.stat)
);

// File: tb/tb_adcseq_regs.sv
`timescale 1ns/1ps
module tb_adcseq_regs;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        conv_start, conv_lowref, conv_pd;
    logic [1:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    adcseq_regs dut (.*);

    // converter stub
    logic [11:0] stub_base = '0;
    int          stub_cnt = 0, starts = 0;
    logic [1:0]  first_ch, last_ch, run_ch;
    logic        last_lref;
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            if (starts == 0) first_ch <= conv_chan;
            last_ch   <= conv_chan;
            run_ch    <= conv_chan;
            last_lref <= conv_lowref;
            starts    <= starts + 1;
            stub_cnt  <= LAT;
        end else if (stub_cnt > 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= stub_base ^ (12'(run_ch) << 8);
            end
        end
    end

    function automatic logic [11:0] exp_val(input logic [11:0] b, input logic [1:0] ch);
        return b ^ (12'(ch) << 8);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] dt);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = dt;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        v = rd_data;
    endtask

    task automatic poll_idle(output logic [31:0] v);
        for (int i = 0; i < 100; i++) begin
            rd(8'h00, 2'd2, v);
            if (v[1:0] == 2'b00) break;
        end
    endtask

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [11:0] prev_smp;
        int s0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 start", {31'b0, conv_start}, 0);
        check("R1 pd", {31'b0, conv_pd}, 0);
        rd(8'h00, 2'd2, v); check("R1 enable", v, 0);
        rd(8'h0C, 2'd2, v); check("R1 status", v, 0);
        rd(8'h20, 2'd1, v); check("R1 sample", v, 0);
        rd(8'h1C, 2'd1, v); check("R1 battery", v, 0);
        rd(8'h28, 2'd2, v); check("R1 divider", v, 0);

        // R2 / R10 lane writes and plain registers
        wr(8'h28, 2'd2, 32'h1122_3344);
        wr(8'h29, 2'd0, 32'h0000_AB00);
        rd(8'h28, 2'd2, v); check("R2 byte lane1", v, 32'h1122_AB44);
        wr(8'h2A, 2'd1, 32'h5566_0000);
        rd(8'h28, 2'd2, v); check("R2 upper half", v, 32'h5566_AB44);
        wr(8'h08, 2'd0, 32'h0000_00FF);
        rd(8'h08, 2'd2, v); check("R10 control", v, 32'hFF);
        wr(8'h20, 2'd2, 32'h0000_0ABC);
        rd(8'h20, 2'd2, v); check("R10 sample read-only", v, 0);
        wr(8'h04, 2'd2, 32'h0000_0013);
        rd(8'h04, 2'd2, v); check("R2 cfg fields", v, 32'h13);

        // R8 power-down blocks starts
        s0 = starts;
        wr(8'h00, 2'd0, 32'h83);
        rd(8'h00, 2'd2, v); check("R8 enable readback", v, 32'h80);
        check("R8 conv_pd", {31'b0, conv_pd}, 1);
        repeat (LAT + 4) @(negedge clk);
        check("R8 no start", starts, s0);
        wr(8'h00, 2'd0, 32'h00);

        // random rounds: R3 R4 R5 R6 R9
        for (int it = 0; it < 40; it++) begin
            logic [1:0]  mx, sel;
            logic        lr;
            logic [11:0] base;
            logic [1:0]  sch;
            mx   = 2'($urandom_range(0, 3));
            lr   = 1'($urandom_range(0, 1));
            sel  = 2'($urandom_range(1, 3));
            base = 12'($urandom);
            if (it == 0) sel = 2'd3;
            sch = (mx == 2'd1) ? 2'd1 : 2'd0;
            wr(8'h0C, 2'd0, 32'h3);
            wr(8'h04, 2'd0, {27'b0, lr, 2'b00, mx});
            stub_base = base;
            s0 = starts;
            wr(8'h00, 2'd0, {30'b0, sel});
            poll_idle(v);
            check("R5 enable cleared", v, 0);
            check("R9 start count", starts - s0, (sel == 2'd3) ? 2 : 1);
            rd(8'h0C, 2'd2, v); check("R6 status set", v, {30'b0, sel});
            if (sel[0]) begin
                rd(8'h20, 2'd1, v);
                check("R3 sample result", v, {20'b0, exp_val(base, sch)});
            end
            if (sel[1]) begin
                rd(8'h1C, 2'd1, v);
                check("R4 battery result", v, {20'b0, exp_val(base, 2'd2)});
                check("R4 lowref", {31'b0, last_lref}, {31'b0, lr});
                check("R9 battery last", {30'b0, last_ch}, 2);
            end else begin
                check("R3 channel", {30'b0, last_ch}, {30'b0, sch});
            end
        end
        check("R9 sample first", {30'b0, first_ch}, {30'b0, 2'd0});

        // R6 write-1-to-clear one bit at a time
        stub_base = 12'h055;
        wr(8'h00, 2'd0, 32'h3);
        poll_idle(v);
        wr(8'h0C, 2'd0, 32'h1);
        rd(8'h0C, 2'd2, v); check("R6 clear bit0 only", v, 2);
        wr(8'h0C, 2'd0, 32'h0);
        rd(8'h0C, 2'd2, v); check("R6 zero write no effect", v, 2);
        wr(8'h0C, 2'd0, 32'h2);
        rd(8'h0C, 2'd2, v); check("R6 clear bit1", v, 0);

        // R7 abort
        wr(8'h04, 2'd0, 32'h0);
        rd(8'h20, 2'd1, v); prev_smp = v[11:0];
        stub_base = 12'hFA5;
        wr(8'h00, 2'd0, 32'h1);
        wr(8'h00, 2'd0, 32'h0);
        repeat (LAT + 6) @(negedge clk);
        rd(8'h20, 2'd1, v); check("R7 result kept", v, {20'b0, prev_smp});
        rd(8'h0C, 2'd2, v); check("R7 status clear", v, 0);
        rd(8'h00, 2'd2, v); check("R7 enable clear", v, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule